// File: doc/BRIEF.md
# Buffered Processor Port for a Serial Channel

This block sits between a byte-wide processor bus and the serial side of one communication channel. It holds two four-entry queues. The receive queue is filled from the serial side, and each entry keeps a data byte together with a few status bits for that character. The transmit queue is filled from the bus, and each entry keeps a data byte together with a few command bits that the serializer acts on. The serial side reaches both queues through plain push and pop ports.

The bus is asynchronous in style. A cycle is live only while chip select and one of the two strobes are both low. It therefore begins when the later of the two falls and ends when the first of the two rises. The block answers on an active-low ready line. If the processor reads from an empty receive queue, or writes to a full transmit queue, ready is held back until the queue can serve the access. Ready stays high after the cycle ends. The processor can read a status register that shows the status bits of the oldest received character before that character is popped.

A flow-control output tells the remote sender to pause while the receive queue is full. A character that arrives at a full receive queue is discarded, and a sticky overrun flag records the loss.

Top module: `sio_fifo_port`

## Requirements
- R1: After reset both queues are empty, `rdy_n` is 1, `stop_remote` is 0, `tx_valid` is 0, and a status read returns 8'h08.
- R2: A completed read with `addr[2]`=0 pops the receive queue and returns the oldest data byte on `rdata`. Characters come out in arrival order.
- R3: A completed read with `addr[2]`=1 returns the status byte and pops nothing. In the status byte, bits 2:0 hold the status bits of the oldest received entry (0 when the queue is empty), bit 3 is receive-empty, bit 4 is transmit-full, and bit 7 is overrun.
- R4: A completed write with `addr[2]`=0 pushes `wdata` into the transmit queue with command bits equal to `addr[1:0]`. The serial side sees the entries in order on `tx_data`/`tx_cmd` while `tx_valid` is 1, and `tx_pop` removes the head.
- R5: A data read from an empty receive queue keeps `rdy_n` at 1 until a character is pushed. The read then completes and returns that character.
- R6: A data write to a full transmit queue keeps `rdy_n` at 1 until `tx_pop` frees an entry. The byte is then stored behind the existing entries.
- R7: A strobe without chip select, or chip select without a strobe, does nothing. When the cycle ends, `rdy_n` returns to 1 at the next clock, and it stays 0 while a completed cycle is still held. A waiting cycle that ends before it completes pops and pushes nothing.
- R8: `stop_remote` is 1 exactly while the receive queue holds four entries.
- R9: A push to a full receive queue (with no pop in the same cycle) is discarded and sets the overrun flag. The flag stays set until a completed write with `addr[2]`=1 and `wdata[7]`=1. A write with `wdata[7]`=0 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Bit 2 selects status (1) or queue (0); bits 1:0 give transmit command bits |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while `rdy_n` is 0 |
| rdy_n | output | 1 | Ready, active low; 0 means the access has completed |
| stop_remote | output | 1 | Flow control: 1 while the receive queue is full |
| rx_push | input | 1 | Serial side pushes a received character |
| rx_data | input | 8 | Received data byte |
| rx_stat | input | 3 | Status bits for the received character |
| tx_pop | input | 1 | Serial side removes the transmit head |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_data | output | 8 | Transmit head data byte |
| tx_cmd | output | 2 | Transmit head command bits |

## Verification
The assertions check the ready handshake on every cycle. Ready must stay low while a completed cycle is held, must return high once the cycle ends, and may only fall on a queue access if that queue could serve it. They also check that the flow-control output can only rise on a push, and that the overrun flag holds until a clear. Data ordering, the pairing of each byte with its status or command bits, and the drop of an overflowing character can only be shown by the bench's scenarios. The same holds for an abandoned wait leaving the queues untouched and for the exact status encoding.

// File: rtl/sio_fifo_pkg.sv
package sio_fifo_pkg;

    parameter int DATA_W     = 8;
    parameter int STAT_W     = 3;
    parameter int CMD_W      = 2;
    parameter int FIFO_DEPTH = 4;

    localparam int ADDR_W        = CMD_W + 1;
    localparam int ST_RXEMPTY    = 3;
    localparam int ST_TXFULL     = 4;
    localparam int ST_OVERRUN    = 7;
    localparam int OVR_CLEAR_BIT = 7;

    typedef struct packed {
        logic [STAT_W-1:0] stat;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_WAIT,
        BUS_DONE
    } bus_state_e;

    typedef enum logic [1:0] {
        ACC_RX_DATA,
        ACC_TX_DATA,
        ACC_STAT_RD,
        ACC_STAT_WR
    } acc_kind_e;

    function automatic acc_kind_e decode_access(input logic is_read, input logic sel_stat);
        if (is_read) return sel_stat ? ACC_STAT_RD : ACC_RX_DATA;
        else         return sel_stat ? ACC_STAT_WR : ACC_TX_DATA;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(
        input logic [STAT_W-1:0] head_stat,
        input logic              rx_empty,
        input logic              tx_full,
        input logic              overrun
    );
        logic [DATA_W-1:0] r;
        r = '0;
        if (!rx_empty) r[STAT_W-1:0] = head_stat;
        r[ST_RXEMPTY] = rx_empty;
        r[ST_TXFULL]  = tx_full;
        r[ST_OVERRUN] = overrun;
        return r;
    endfunction

endpackage

// File: rtl/sio_fifo.sv
module sio_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          pop_ok, push_ok;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign pop_ok  = pop & ~empty;
    assign push_ok = push & (~full | pop_ok);
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (push_ok) wptr <= step(wptr);
            if (pop_ok)  rptr <= step(rptr);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/sio_bus_ctrl.sv
module sio_bus_ctrl
    import sio_fifo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_n,
    input  logic      rd_n,
    input  logic      wr_n,
    input  logic      sel_stat,
    input  logic      rx_empty,
    input  logic      tx_full,
    output logic      go,
    output acc_kind_e kind,
    output logic      rdy_n
);
    bus_state_e state, nxt;
    logic       rd_cyc, wr_cyc, active, blocked;

    assign rd_cyc  = ~cs_n & ~rd_n;
    assign wr_cyc  = ~cs_n & ~wr_n;
    assign active  = rd_cyc | wr_cyc;
    assign kind    = decode_access(rd_cyc, sel_stat);
    assign blocked = ((kind == ACC_RX_DATA) && rx_empty) ||
                     ((kind == ACC_TX_DATA) && tx_full);

    always_comb begin
        nxt = state;
        go  = 1'b0;
        case (state)
            BUS_IDLE, BUS_WAIT: begin
                if (!active) begin
                    nxt = BUS_IDLE;
                end else if (!blocked) begin
                    go  = 1'b1;
                    nxt = BUS_DONE;
                end else begin
                    nxt = BUS_WAIT;
                end
            end
            BUS_DONE: if (!active) nxt = BUS_IDLE;
            default:  nxt = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= BUS_IDLE;
        else     state <= nxt;
    end

    assign rdy_n = (state != BUS_DONE);
endmodule

// File: rtl/sio_fifo_port.sv
module sio_fifo_port
    import sio_fifo_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdy_n,
    output logic              stop_remote,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [STAT_W-1:0] rx_stat,
    input  logic              tx_pop,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic [CMD_W-1:0]  tx_cmd
);
    localparam int RXW = $bits(rx_entry_t);
    localparam int TXW = $bits(tx_entry_t);

    rx_entry_t   rx_in, rx_head;
    tx_entry_t   tx_in, tx_head;
    logic        rx_empty, rx_full, tx_empty, tx_full;
    logic        go, rx_pop, tx_push;
    acc_kind_e   kind;
    logic        ovr_q, ovr_set, ovr_clr;
    logic [DATA_W-1:0] rdata_q;

    sio_bus_ctrl u_bus (
        .clk      (clk),
        .rst      (rst),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .sel_stat (addr[ADDR_W-1]),
        .rx_empty (rx_empty),
        .tx_full  (tx_full),
        .go       (go),
        .kind     (kind),
        .rdy_n    (rdy_n)
    );

    assign rx_in   = '{stat: rx_stat, data: rx_data};
    assign rx_pop  = go && (kind == ACC_RX_DATA);

    sio_fifo #(.W(RXW), .DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .push  (rx_push),
        .din   (rx_in),
        .pop   (rx_pop),
        .head  (rx_head),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign tx_in   = '{cmd: addr[CMD_W-1:0], data: wdata};
    assign tx_push = go && (kind == ACC_TX_DATA);

    sio_fifo #(.W(TXW), .DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (tx_push),
        .din   (tx_in),
        .pop   (tx_pop),
        .head  (tx_head),
        .empty (tx_empty),
        .full  (tx_full)
    );

    assign ovr_set = rx_push & rx_full & ~rx_pop;
    assign ovr_clr = go && (kind == ACC_STAT_WR) && wdata[OVR_CLEAR_BIT];

    always_ff @(posedge clk) begin
        if (rst)          ovr_q <= 1'b0;
        else if (ovr_set) ovr_q <= 1'b1;
        else if (ovr_clr) ovr_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (go) begin
            if (kind == ACC_RX_DATA)
                rdata_q <= rx_head.data;
            else if (kind == ACC_STAT_RD)
                rdata_q <= pack_status(rx_head.stat, rx_empty, tx_full, ovr_q);
        end
    end

    assign rdata       = rdata_q;
    assign stop_remote = rx_full;
    assign tx_valid    = ~tx_empty;
    assign tx_data     = tx_head.data;
    assign tx_cmd      = tx_head.cmd;
endmodule

// File: rtl/sio_fifo_port_chk.sv
module sio_fifo_port_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic              rdy_n,
    input logic              stop_remote,
    input logic              rx_push,
    input logic              rx_empty,
    input logic              tx_full,
    input logic              ovr_q,
    input logic              ovr_clr
);
    logic cyc, rx_rd_cyc, tx_wr_cyc;
    assign cyc       = ~cs_n & (~rd_n | ~wr_n);
    assign rx_rd_cyc = ~cs_n & ~rd_n & ~addr[ADDR_W-1];
    assign tx_wr_cyc = ~cs_n & ~wr_n & rd_n & ~addr[ADDR_W-1];

    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && !cyc) |=> rdy_n);  // R7

    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rdy_n && cyc) |=> !rdy_n);  // R7

    AST_RX_NO_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        ($fell(rdy_n) && $past(rx_rd_cyc)) |-> !$past(rx_empty));  // R5

    AST_TX_NO_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        ($fell(rdy_n) && $past(tx_wr_cyc)) |-> !$past(tx_full));  // R6

    AST_STOP_ON_PUSH: assert property (@(posedge clk) disable iff (rst)
        $rose(stop_remote) |-> $past(rx_push));  // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovr_q && !ovr_clr) |=> ovr_q);  // R9
endmodule

bind sio_fifo_port sio_fifo_port_chk #(.ADDR_W(sio_fifo_pkg::ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n        (cs_n),
    .rd_n        (rd_n),
    .wr_n        (wr_n),
    .addr        (addr),
    .rdy_n       (rdy_n),
    .stop_remote (stop_remote),
    .rx_push     (rx_push),
    .rx_empty    (rx_empty),
    .tx_full     (tx_full),
    .ovr_q       (ovr_q),
    .ovr_clr     (ovr_clr)
);

// File: tb/sio_fifo_port_test.sv
module sio_fifo_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rdy_n, stop_remote;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_stat = '0;
    logic       tx_pop = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic [1:0] tx_cmd;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sio_fifo_port uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdy_n(rdy_n),
        .stop_remote(stop_remote), .rx_push(rx_push), .rx_data(rx_data),
        .rx_stat(rx_stat), .tx_pop(tx_pop), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_cmd(tx_cmd)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_rdy();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rdy_n && n < 50);
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        wait_rdy();
        d = rdata;
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        wait_rdy();
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ser_push(input logic [7:0] d, input logic [2:0] s);
        @(negedge clk);
        rx_push = 1'b1; rx_data = d; rx_stat = s;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic ser_pop_check(input logic [7:0] d, input logic [1:0] c);
        @(negedge clk);
        chk("R4 tx_valid", {7'd0, tx_valid}, 8'd1);
        chk("R4 tx_data", tx_data, d);
        chk("R4 tx_cmd", {6'd0, tx_cmd}, {6'd0, c});
        tx_pop = 1'b1;
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 rdy_n", {7'd0, rdy_n}, 8'd1);
        chk("R1 stop_remote", {7'd0, stop_remote}, 8'd0);
        chk("R1 tx_valid", {7'd0, tx_valid}, 8'd0);
        bus_read(3'b100, d);
        chk("R1 status", d, 8'h08);
        chk("R7 rdy_n released", {7'd0, rdy_n}, 8'd1);
    endtask

    task automatic t_rx_order();
        logic [7:0] d;
        ser_push(8'hA1, 3'd1);
        ser_push(8'hA2, 3'd2);
        ser_push(8'hA3, 3'd5);
        chk("R8 not full at 3", {7'd0, stop_remote}, 8'd0);
        ser_push(8'hA4, 3'd7);
        chk("R8 full at 4", {7'd0, stop_remote}, 8'd1);
        bus_read(3'b100, d);
        chk("R3 head status", d, 8'h01);
        chk("R3 status read no pop", {7'd0, stop_remote}, 8'd1);
        bus_read(3'b000, d);
        chk("R2 first", d, 8'hA1);
        chk("R8 released", {7'd0, stop_remote}, 8'd0);
        bus_read(3'b100, d);
        chk("R3 next status", d, 8'h02);
        bus_read(3'b000, d);
        chk("R2 second", d, 8'hA2);
        bus_read(3'b100, d);
        chk("R3 third status", d, 8'h05);
        bus_read(3'b000, d);
        chk("R2 third", d, 8'hA3);
        bus_read(3'b000, d);
        chk("R2 fourth", d, 8'hA4);
        bus_read(3'b100, d);
        chk("R3 empty status", d, 8'h08);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        ser_push(8'h31, 3'd3);
        ser_push(8'h32, 3'd1);
        ser_push(8'h33, 3'd2);
        ser_push(8'h34, 3'd4);
        ser_push(8'hEE, 3'd6);
        bus_read(3'b100, d);
        chk("R9 overrun set", d, 8'h83);
        bus_write(3'b100, 8'h00);
        bus_read(3'b100, d);
        chk("R9 write 0 keeps flag", d, 8'h83);
        bus_write(3'b100, 8'h80);
        bus_read(3'b100, d);
        chk("R9 flag cleared", d, 8'h03);
        bus_read(3'b000, d); chk("R9 drain 1", d, 8'h31);
        bus_read(3'b000, d); chk("R9 drain 2", d, 8'h32);
        bus_read(3'b000, d); chk("R9 drain 3", d, 8'h33);
        bus_read(3'b000, d); chk("R9 drain 4", d, 8'h34);
        bus_read(3'b100, d);
        chk("R9 dropped byte absent", d, 8'h08);
    endtask

    task automatic t_tx();
        logic [7:0] d;
        bus_write(3'b001, 8'h11);
        bus_write(3'b010, 8'h22);
        bus_write(3'b011, 8'h33);
        bus_write(3'b000, 8'h44);
        bus_read(3'b100, d);
        chk("R3 tx full bit", d, 8'h18);
        @(negedge clk);
        addr = 3'b011; wdata = 8'h55; cs_n = 1'b0; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R6 wait on full", {7'd0, rdy_n}, 8'd1);
        ser_pop_check(8'h11, 2'd1);
        wait_rdy();
        chk("R6 completes", {7'd0, rdy_n}, 8'd0);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
        ser_pop_check(8'h22, 2'd2);
        ser_pop_check(8'h33, 2'd3);
        ser_pop_check(8'h44, 2'd0);
        ser_pop_check(8'h55, 2'd3);
        @(negedge clk);
        chk("R4 drained", {7'd0, tx_valid}, 8'd0);
    endtask

    task automatic t_rx_wait();
        @(negedge clk);
        addr = 3'b000; cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 wait on empty", {7'd0, rdy_n}, 8'd1);
        rx_push = 1'b1; rx_data = 8'h5A; rx_stat = 3'd6;
        @(negedge clk);
        rx_push = 1'b0;
        wait_rdy();
        chk("R5 completes", {7'd0, rdy_n}, 8'd0);
        chk("R5 data", rdata, 8'h5A);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        chk("R7 release after wait", {7'd0, rdy_n}, 8'd1);
    endtask

    task automatic t_gating();
        logic [7:0] d;
        @(negedge clk);
        addr = 3'b000; cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        ser_push(8'h77, 3'd4);
        repeat (2) @(negedge clk);
        chk("R7 strobe without select", {7'd0, rdy_n}, 8'd1);
        rd_n = 1'b1;
        bus_read(3'b100, d);
        chk("R7 abandoned read kept entry", d, 8'h04);
        @(negedge clk);
        addr = 3'b000; wdata = 8'h99; wr_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 write without select", {7'd0, tx_valid}, 8'd0);
        wr_n = 1'b1; cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 select without strobe", {7'd0, rdy_n}, 8'd1);
        cs_n = 1'b1;
        bus_read(3'b000, d);
        chk("R7 entry intact", d, 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_rx_order();
        t_overrun();
        t_tx();
        t_rx_wait();
        t_gating();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule